// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block is the execute-stage arithmetic-logic unit of a small load/store processor. Each cycle it takes a first operand, a second operand (a register value, or an 8-bit constant widened with zeros), a 4-bit operation code and the current condition flags. It returns a result, a write enable for the destination register, and the next negative, zero, carry and overflow flags. Outputs are registered, so the result of an operation presented in one cycle appears after the next rising clock edge.

The operation set includes plain and carry-chained addition, forward and reverse subtraction (each with a carry-chained form), the four bitwise operations including bit clear, move and move-inverted, and two flag-only comparisons. Subtraction uses the carry flag as an inverted borrow, so chained multi-word subtraction works without extra logic.

Top module: `dp_alu`

## Requirements
- R1: While `rst` is high at a rising edge, every output is cleared to zero on that edge.
- R2: When `b_imm` is 1 the second operand is `imm8` zero-extended to the data width; when `b_imm` is 0 it is `op_b`.
- R3: Code 0x0 (move) returns the second operand; code 0x1 (move inverted) returns its bitwise NOT; both write and leave C and V unchanged.
- R4: Code 0x2 returns A+B and code 0x3 returns A+B+C; C is the unsigned carry out of bit 31 and V is signed overflow.
- R5: Code 0x4 returns A-B and code 0x5 returns A+~B+C; C is 1 exactly when no borrow occurs; V is signed overflow.
- R6: Code 0x6 returns B-A and code 0x7 returns B+~A+C, with carry and overflow as in R5 with the operands swapped.
- R7: Codes 0x8 (AND), 0x9 (OR), 0xA (XOR) and 0xB (A AND NOT B) return the bitwise result, write it, and leave C and V unchanged.
- R8: Code 0xC computes A-B and code 0xD computes A+B for the flags only, with carry and overflow as in R5 and R4; `wr_en` stays 0.
- R9: For every code 0x0 to 0xD, N equals result bit 31 and Z is 1 exactly when the 32-bit result is zero.
- R10: Codes 0xE and 0xF give a zero result, `wr_en` 0, and all four flags equal to their inputs.
- R11: Outputs reflect the inputs sampled at the previous rising edge; back-to-back operations each appear one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 4 | Operation code |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Register second operand |
| b_imm | input | 1 | Selects the immediate as second operand |
| imm8 | input | 8 | Immediate constant |
| flag_n_in | input | 1 | Current negative flag |
| flag_z_in | input | 1 | Current zero flag |
| flag_c_in | input | 1 | Current carry flag |
| flag_v_in | input | 1 | Current overflow flag |
| result | output | 32 | Registered result |
| wr_en | output | 1 | Registered destination write enable |
| flag_n | output | 1 | Next negative flag |
| flag_z | output | 1 | Next zero flag |
| flag_c | output | 1 | Next carry flag |
| flag_v | output | 1 | Next overflow flag |

## Verification
On every cycle the assertions check that comparisons never write, that N and Z agree with the registered result, that bitwise and move codes preserve C and V, that the reserved codes give zero with flags passed through, that immediates reach move zero-extended, and that add overflow matches the operand signs. Exact arithmetic values, carry as no-borrow across the chained and reversed subtraction forms, and the behaviour at the corner operands 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF are shown only by the bench, which compares every code against an independent signed and unsigned model.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [3:0] {
    OP_MOVE  = 4'h0,
    OP_MOVN  = 4'h1,
    OP_ADD   = 4'h2,
    OP_ADDC  = 4'h3,
    OP_SUB   = 4'h4,
    OP_SUBC  = 4'h5,
    OP_RSUB  = 4'h6,
    OP_RSUBC = 4'h7,
    OP_AND   = 4'h8,
    OP_OR    = 4'h9,
    OP_XOR   = 4'hA,
    OP_BCLR  = 4'hB,
    OP_CMP   = 4'hC,
    OP_CMPN  = 4'hD,
    OP_RSV0  = 4'hE,
    OP_RSV1  = 4'hF
  } alu_op_e;

  function automatic logic op_is_arith(alu_op_e op);
    return (op inside {OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSUB,
                       OP_RSUBC, OP_CMP, OP_CMPN});
  endfunction

  function automatic logic op_is_bitwise(alu_op_e op);
    return (op inside {OP_MOVE, OP_MOVN, OP_AND, OP_OR, OP_XOR, OP_BCLR});
  endfunction

  function automatic logic op_is_compare(alu_op_e op);
    return (op inside {OP_CMP, OP_CMPN});
  endfunction
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 8
) (
  input  logic [WIDTH-1:0] reg_val,
  input  logic [IMM_W-1:0] imm_val,
  input  logic             use_imm,
  output logic [WIDTH-1:0] operand
);
  localparam int PAD_W = WIDTH - IMM_W;

  always_comb begin
    if (use_imm) operand = {{PAD_W{1'b0}}, imm_val};
    else         operand = reg_val;
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             c_in,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             v_out
);
  localparam int EXT_W = WIDTH + 1;
  localparam int MSB   = WIDTH - 1;

  logic [WIDTH-1:0] x, y;
  logic             cin;
  logic [EXT_W-1:0] total;

  always_comb begin
    x = a; y = b; cin = 1'b0;
    unique case (op)
      OP_ADD, OP_CMPN: begin x = a; y = b;  cin = 1'b0; end
      OP_ADDC:         begin x = a; y = b;  cin = c_in; end
      OP_SUB, OP_CMP:  begin x = a; y = ~b; cin = 1'b1; end
      OP_SUBC:         begin x = a; y = ~b; cin = c_in; end
      OP_RSUB:         begin x = b; y = ~a; cin = 1'b1; end
      OP_RSUBC:        begin x = b; y = ~a; cin = c_in; end
      default:         begin x = a; y = b;  cin = 1'b0; end
    endcase
  end

  always_comb begin
    total = {1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin};
    sum   = total[WIDTH-1:0];
    c_out = total[WIDTH];
    v_out = (x[MSB] == y[MSB]) && (total[MSB] != x[MSB]);
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);
  always_comb begin
    unique case (op)
      OP_MOVE: res = b;
      OP_MOVN: res = ~b;
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_BCLR: res = a & ~b;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic             b_imm,
  input  logic [IMM_W-1:0] imm8,
  input  logic             flag_n_in,
  input  logic             flag_z_in,
  input  logic             flag_c_in,
  input  logic             flag_v_in,
  output logic [WIDTH-1:0] result,
  output logic             wr_en,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_c,
  output logic             flag_v
);
  localparam int MSB = WIDTH - 1;

  alu_op_e          op;
  logic [WIDTH-1:0] opnd_b;
  logic [WIDTH-1:0] arith_res, bit_res, res_d;
  logic             arith_c, arith_v;
  logic             is_arith, is_bit, is_cmp, is_valid;
  logic             wr_d, n_d, z_d, c_d, v_d;

  assign op = alu_op_e'(op_sel);

  alu_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
    .reg_val (op_b),
    .imm_val (imm8),
    .use_imm (b_imm),
    .operand (opnd_b)
  );

  alu_adder #(.WIDTH(WIDTH)) u_add (
    .op    (op),
    .a     (op_a),
    .b     (opnd_b),
    .c_in  (flag_c_in),
    .sum   (arith_res),
    .c_out (arith_c),
    .v_out (arith_v)
  );

  alu_bitwise #(.WIDTH(WIDTH)) u_bit (
    .op  (op),
    .a   (op_a),
    .b   (opnd_b),
    .res (bit_res)
  );

  always_comb begin
    is_arith = op_is_arith(op);
    is_bit   = op_is_bitwise(op);
    is_cmp   = op_is_compare(op);
    is_valid = is_arith || is_bit;
    if (is_arith)    res_d = arith_res;
    else if (is_bit) res_d = bit_res;
    else             res_d = '0;
    wr_d = is_valid && !is_cmp;
    n_d  = is_valid ? res_d[MSB]     : flag_n_in;
    z_d  = is_valid ? (res_d == '0)  : flag_z_in;
    c_d  = is_arith ? arith_c        : flag_c_in;
    v_d  = is_arith ? arith_v        : flag_v_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      wr_en  <= 1'b0;
      flag_n <= 1'b0;
      flag_z <= 1'b0;
      flag_c <= 1'b0;
      flag_v <= 1'b0;
    end else begin
      result <= res_d;
      wr_en  <= wr_d;
      flag_n <= n_d;
      flag_z <= z_d;
      flag_c <= c_d;
      flag_v <= v_d;
    end
  end

  // Compare codes never write a destination.
  assert_cmp_nowrite_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(op_sel) == 4'hC || $past(op_sel) == 4'hD)) |-> !wr_en);

  // N and Z follow the written result.
  assert_nz_match_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && wr_en) |-> (flag_n == result[MSB] && flag_z == (result == '0)));

  // Bitwise and move codes keep carry and overflow.
  assert_cv_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) inside {4'h0, 4'h1, 4'h8, 4'h9, 4'hA, 4'hB})
    |-> (flag_c == $past(flag_c_in) && flag_v == $past(flag_v_in)));

  // Reserved codes: zero, no write, flags passed through.
  assert_reserved_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) >= 4'hE)
    |-> (result == '0 && !wr_en && flag_n == $past(flag_n_in) && flag_z == $past(flag_z_in)
         && flag_c == $past(flag_c_in) && flag_v == $past(flag_v_in)));

  // Immediate move yields the constant zero-extended.
  assert_imm_move_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 4'h0 && $past(b_imm))
    |-> (result == {{(WIDTH-IMM_W){1'b0}}, $past(imm8)}));

  // Plain add overflow follows operand and result signs.
  assert_add_ovf_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 4'h2 && !$past(b_imm))
    |-> (flag_v == (($past(op_a[MSB]) == $past(op_b[MSB])) && (result[MSB] != $past(op_a[MSB])))));
endmodule

// File: tb/dp_alu_test.sv
module dp_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op_sel = '0;
  logic [31:0] op_a = '0, op_b = '0;
  logic        b_imm = 1'b0;
  logic [7:0]  imm8 = '0;
  logic        fn_i = 0, fz_i = 0, fc_i = 0, fv_i = 0;
  logic [31:0] result;
  logic        wr_en, flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dp_alu uut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .op_a(op_a), .op_b(op_b),
    .b_imm(b_imm), .imm8(imm8), .flag_n_in(fn_i), .flag_z_in(fz_i),
    .flag_c_in(fc_i), .flag_v_in(fv_i), .result(result), .wr_en(wr_en),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  // Independent model: {result, wr, n, z, c, v}
  function automatic logic [36:0] model(input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic ni, zi, ci, vi);
    logic [31:0] r; logic wr, n, z, c, v, ar;
    longint sa, sb, sr; longint unsigned ua, ub, u, bw;
    sa = longint'($signed(a)); sb = longint'($signed(b));
    ua = {32'd0, a}; ub = {32'd0, b};
    bw = ci ? 64'd0 : 64'd1;
    r = '0; c = ci; v = vi; sr = 0; ar = 1'b1;
    case (op)
      4'h0: begin r = b;      ar = 0; end
      4'h1: begin r = ~b;     ar = 0; end
      4'h8: begin r = a & b;  ar = 0; end
      4'h9: begin r = a | b;  ar = 0; end
      4'hA: begin r = a ^ b;  ar = 0; end
      4'hB: begin r = a & ~b; ar = 0; end
      4'h2, 4'hD: begin u = ua + ub; r = u[31:0]; c = u[32]; sr = sa + sb; end
      4'h3: begin u = ua + ub + (ci ? 64'd1 : 64'd0); r = u[31:0]; c = u[32];
                  sr = sa + sb + (ci ? 1 : 0); end
      4'h4, 4'hC: begin r = a - b; c = (ua >= ub); sr = sa - sb; end
      4'h5: begin r = a - b - bw[31:0]; c = (ua >= ub + bw); sr = sa - sb - longint'(bw); end
      4'h6: begin r = b - a; c = (ub >= ua); sr = sb - sa; end
      4'h7: begin r = b - a - bw[31:0]; c = (ub >= ua + bw); sr = sb - sa - longint'(bw); end
      default: ar = 0;
    endcase
    if (op >= 4'hE) begin
      return {32'd0, 1'b0, ni, zi, ci, vi};
    end
    if (ar) v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
    wr = !(op == 4'hC || op == 4'hD);
    n = r[31]; z = (r == 32'd0);
    return {r, wr, n, z, c, v};
  endfunction

  task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got res=%h wr=%b nzcv=%b expected res=%h wr=%b nzcv=%b",
               req, got[36:5], got[4], got[3:0], exp[36:5], exp[4], exp[3:0]);
    end
  endtask

  function automatic logic [36:0] outs();
    return {result, wr_en, flag_n, flag_z, flag_c, flag_v};
  endfunction

  // Drive one operation, sample one cycle later (R11).
  task automatic run(input string req, input logic [3:0] op, input logic [31:0] a,
      input logic [31:0] b, input logic [3:0] nzcv, input logic imm, input logic [7:0] k);
    logic [31:0] beff;
    @(negedge clk);
    op_sel = op; op_a = a; op_b = b; b_imm = imm; imm8 = k;
    {fn_i, fz_i, fc_i, fv_i} = nzcv;
    beff = imm ? {24'd0, k} : b;
    @(negedge clk);
    check(req, outs(), model(op, a, beff, nzcv[3], nzcv[2], nzcv[1], nzcv[0]));
  endtask

  task automatic test_reset();
    @(negedge clk);
    rst = 1; op_sel = 4'h1; op_a = 32'h1234; op_b = 32'h0; fc_i = 1; fv_i = 1;
    @(negedge clk);
    check("R1", outs(), 37'd0);
    rst = 0;
  endtask

  task automatic test_operand_sel();
    run("R2", 4'h0, 32'h0, 32'hDEADBEEF, 4'b0000, 1'b1, 8'hFF);
    run("R2", 4'h2, 32'h100, 32'hFFFFFFFF, 4'b0000, 1'b1, 8'h80);
    run("R2", 4'h0, 32'h0, 32'hDEADBEEF, 4'b0000, 1'b0, 8'hFF);
  endtask

  task automatic test_moves();
    run("R3", 4'h0, 32'h5, 32'h0, 4'b0011, 1'b0, 8'h0);
    run("R3", 4'h1, 32'h5, 32'h0, 4'b0010, 1'b0, 8'h0);
    run("R3", 4'h1, 32'h0, 32'hFFFFFFFF, 4'b0001, 1'b0, 8'h0);
  endtask

  task automatic test_add();
    run("R4", 4'h2, 32'h7FFFFFFF, 32'h1, 4'b0000, 1'b0, 8'h0);
    run("R4", 4'h2, 32'hFFFFFFFF, 32'h1, 4'b0000, 1'b0, 8'h0);
    run("R4", 4'h2, 32'h80000000, 32'h80000000, 4'b0000, 1'b0, 8'h0);
    run("R4", 4'h3, 32'hFFFFFFFE, 32'h1, 4'b0010, 1'b0, 8'h0);
    run("R4", 4'h3, 32'h7FFFFFFE, 32'h1, 4'b0010, 1'b0, 8'h0);
  endtask

  task automatic test_sub();
    run("R5", 4'h4, 32'h5, 32'h5, 4'b0000, 1'b0, 8'h0);
    run("R5", 4'h4, 32'h0, 32'h1, 4'b0000, 1'b0, 8'h0);
    run("R5", 4'h4, 32'h80000000, 32'h1, 4'b0000, 1'b0, 8'h0);
    run("R5", 4'h5, 32'h5, 32'h5, 4'b0000, 1'b0, 8'h0);
    run("R5", 4'h5, 32'h5, 32'h5, 4'b0010, 1'b0, 8'h0);
  endtask

  task automatic test_rsub();
    run("R6", 4'h6, 32'h3, 32'h10, 4'b0000, 1'b0, 8'h0);
    run("R6", 4'h6, 32'h10, 32'h3, 4'b0000, 1'b0, 8'h0);
    run("R6", 4'h7, 32'h1, 32'h80000000, 4'b0010, 1'b0, 8'h0);
    run("R6", 4'h7, 32'h0, 32'h0, 4'b0000, 1'b0, 8'h0);
  endtask

  task automatic test_logic();
    run("R7", 4'h8, 32'hF0F0F0F0, 32'hFF00FF00, 4'b0011, 1'b0, 8'h0);
    run("R7", 4'h9, 32'h0F0F0000, 32'h000000F0, 4'b0001, 1'b0, 8'h0);
    run("R7", 4'hA, 32'hAAAAAAAA, 32'hAAAAAAAA, 4'b0010, 1'b0, 8'h0);
    run("R7", 4'hB, 32'hFFFFFFFF, 32'h0000FFFF, 4'b0011, 1'b0, 8'h0);
  endtask

  task automatic test_compare();
    run("R8", 4'hC, 32'h7, 32'h7, 4'b0000, 1'b0, 8'h0);
    run("R8", 4'hC, 32'h80000000, 32'h7FFFFFFF, 4'b0000, 1'b0, 8'h0);
    run("R8", 4'hD, 32'hFFFFFFFF, 32'h1, 4'b0000, 1'b0, 8'h0);
  endtask

  task automatic test_flags_nz();
    run("R9", 4'h4, 32'h1, 32'h2, 4'b0100, 1'b0, 8'h0);
    run("R9", 4'hA, 32'h1234, 32'h1234, 4'b1000, 1'b0, 8'h0);
  endtask

  task automatic test_reserved();
    run("R10", 4'hE, 32'hFFFFFFFF, 32'h1, 4'b1010, 1'b0, 8'h0);
    run("R10", 4'hF, 32'h1, 32'h1, 4'b0101, 1'b0, 8'h0);
  endtask

  task automatic test_corners();
    logic [31:0] cv [4];
    cv[0] = 32'h0; cv[1] = 32'h7FFFFFFF; cv[2] = 32'h80000000; cv[3] = 32'hFFFFFFFF;
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          run("R11", op[3:0], cv[i], cv[j], {2'b00, i[0], j[0]}, 1'b0, 8'h0);
    for (int k = 0; k < 400; k++)
      run("R11", 4'($urandom_range(0, 15)), $urandom, $urandom,
          4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
  endtask

  initial begin : watchdog
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    test_reset();
    test_operand_sel();
    test_moves();
    test_add();
    test_sub();
    test_rsub();
    test_logic();
    test_compare();
    test_flags_nz();
    test_reserved();
    test_corners();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule